// File: doc/BRIEF.md
# Multibank DRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate DRAM and turns single-word user requests into a legal stream of memory commands. Each request names a bank, a row and a column and says whether it is a read or a write. The sequencer keeps a record of the open row in every bank. A request that hits the open row goes straight to the column command. A request to a closed bank first opens the row. A request to a bank holding a different row first closes that row and then opens the new one. The gaps between these steps are parameters counted in clock cycles.

After reset the sequencer loads the burst length into the memory's mode setting. From then on it spaces column commands by the burst duration. An optional auto-precharge build marks every column command so that the memory closes the row by itself when the burst ends. A refresh interval timer raises an urgent refresh. Once the current access has finished, the refresh takes precedence over new user requests. If any bank is still open, one close-all command goes out first. At most one command is presented per clock cycle, and the command outputs are registered.

Top module: `dram_cmd_seq`

## Requirements
- R1: The first non-idle command after reset is a mode load (code 1), issued on the first clock edge after reset is released. cmd_addr[2:0] holds the burst code: 1 for 2 beats, 2 for 4 beats, 3 for 8 beats.
- R2: A request to a closed bank issues Activate (code 2) with the row on cmd_addr. Exactly T_RCD cycles later the Read (code 3) or Write (code 4) follows, with the column on cmd_addr, and idle commands (code 0) fill the gap.
- R3: A request whose row is already open in its bank issues the Read or Write directly, with no Activate.
- R4: A request to a bank holding another row issues a single-bank Precharge (code 5, cmd_ap = 0). The Activate follows exactly T_RP cycles later, and the access follows T_RCD cycles after that.
- R5: After a Read or Write, req_ready stays low and no command is issued for at least BURST_LEN/2 cycles, plus T_RP when auto-precharge is built in.
- R6: With AUTO_PRE = 1, every Read and Write carries cmd_ap = 1 and leaves its bank closed, so the next request to that bank starts with Activate.
- R7: Refresh (code 6) is issued periodically, and only when every bank is closed. If any bank is open, a Precharge with cmd_ap = 1 closes all banks exactly T_RP cycles before the Refresh. After a refresh every bank counts as closed.
- R8: While a refresh is pending, req_ready is held low, so a steady stream of requests cannot delay a refresh past the interval by more than one access sequence.
- R9: During reset the command is idle and req_ready is low. A request is accepted only when req_valid and req_ready are both high, and its first command appears in the very next cycle.
- R10: Each bank keeps its own open row; accesses to other banks do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Sequencer can issue the request's first command now |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the burst |
| cmd_code | output | 3 | Command: 0 idle, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh |
| cmd_bank | output | BANK_W | Bank addressed by the command |
| cmd_addr | output | ADDR_W | Row, column or mode word |
| cmd_ap | output | 1 | Auto-precharge on read/write; all banks on precharge |

## Verification
The bench drives two small builds and computes the expected command for every request from its own model of the open rows. One build has 8-beat bursts and no auto-precharge; the other has 2-beat bursts and auto-precharge. Row changes are swept across all four banks so that hits, misses and closed-bank openings are interleaved. Off-by-one delay counters show up as a command one cycle early or late. A stale open-row record shows up as an Activate where a direct access was expected, or the other way round. A refresh issued before closing the banks, or starved by continuous requests, is caught at the refresh itself. A build that forgets auto-precharge would give a direct access on the second visit to a bank, where an Activate is expected.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_MRS = 3'd1,
      CMD_ACT = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4,
      CMD_PRE = 3'd5,
      CMD_REF = 3'd6
   } dcs_cmd_e;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_IDLE,
      ST_ACT,
      ST_CMD,
      ST_REF
   } dcs_state_e;

   // burst length to mode-word code
   function automatic logic [2:0] burst_code(input int bl);
      case (bl)
         2:       return 3'd1;
         4:       return 3'd2;
         default: return 3'd3;
      endcase
   endfunction

endpackage

// File: rtl/dcs_wait_counter.sv
module dcs_wait_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/dcs_bank_state.sv
module dcs_bank_state #(
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (open_set) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end else if (close) begin
         is_open <= 1'b0;
      end
   end

endmodule

// File: rtl/dcs_refresh_timer.sv
module dcs_refresh_timer #(
   parameter int INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_issued,
   output logic pending
);

   localparam int CW = $clog2(INTERVAL);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         pending <= 1'b0;
      end else begin
         if (ref_issued)
            pending <= 1'b0;
         if (cnt == CW'(INTERVAL - 1)) begin
            cnt     <= '0;
            pending <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dcs_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int ROW_W        = 13,
   parameter int COL_W        = 10,
   parameter int BURST_LEN    = 8,
   parameter bit AUTO_PRE     = 1'b0,
   parameter int T_RP         = 3,
   parameter int T_RCD        = 3,
   parameter int T_RFC        = 9,
   parameter int REF_INTERVAL = 780,
   localparam int BANK_W      = $clog2(NUM_BANKS),
   localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic [2:0]        cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_ap
);

   localparam int BURST_GAP = BURST_LEN / 2 + (AUTO_PRE ? T_RP : 0);
   localparam int MAX_A     = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int MAX_B     = (T_RFC > BURST_GAP) ? T_RFC : BURST_GAP;
   localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int WAIT_W    = $clog2(MAX_WAIT + 1);

   // elaboration-time parameter checks
   if (NUM_BANKS != 4) begin : g_bad_banks
      $error("NUM_BANKS must be 4");
   end
   if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end
   if (T_RP < 1 || T_RCD < 1 || T_RFC < 1) begin : g_bad_delay
      $error("delays must be at least one cycle");
   end
   if (ADDR_W < 3 || REF_INTERVAL < 2 * MAX_WAIT + 8) begin : g_bad_misc
      $error("address too narrow or refresh interval too short");
   end

   dcs_state_e state, state_n;
   dcs_cmd_e   cmd_d;
   logic [BANK_W-1:0] bank_d;
   logic [ADDR_W-1:0] addr_d;
   logic              ap_d;
   logic              wload;
   logic [WAIT_W-1:0] wval;
   logic              wzero;
   logic              accept;
   logic              ref_pending;
   logic              rw_close;

   logic              lat_write;
   logic [BANK_W-1:0] lat_bank;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;

   logic [NUM_BANKS-1:0] open_vec;
   logic [NUM_BANKS-1:0] bank_act;
   logic [NUM_BANKS-1:0] bank_pre;
   logic [ROW_W-1:0]     row_arr [NUM_BANKS];

   logic req_hit;
   assign req_hit = open_vec[req_bank] && (row_arr[req_bank] == req_row);

   always_comb begin
      state_n = state;
      cmd_d   = CMD_NOP;
      bank_d  = '0;
      addr_d  = '0;
      ap_d    = 1'b0;
      wload   = 1'b0;
      wval    = '0;
      accept  = 1'b0;
      case (state)
         ST_INIT: begin
            cmd_d   = CMD_MRS;
            addr_d  = ADDR_W'(burst_code(BURST_LEN));
            state_n = ST_IDLE;
         end
         ST_IDLE: begin
            if (wzero) begin
               if (ref_pending) begin
                  wload = 1'b1;
                  if (|open_vec) begin
                     cmd_d   = CMD_PRE;
                     ap_d    = 1'b1;
                     wval    = WAIT_W'(T_RP - 1);
                     state_n = ST_REF;
                  end else begin
                     cmd_d = CMD_REF;
                     wval  = WAIT_W'(T_RFC - 1);
                  end
               end else if (req_valid) begin
                  accept = 1'b1;
                  wload  = 1'b1;
                  bank_d = req_bank;
                  if (req_hit) begin
                     cmd_d  = req_write ? CMD_WR : CMD_RD;
                     addr_d = ADDR_W'(req_col);
                     ap_d   = AUTO_PRE;
                     wval   = WAIT_W'(BURST_GAP - 1);
                  end else if (open_vec[req_bank]) begin
                     cmd_d   = CMD_PRE;
                     wval    = WAIT_W'(T_RP - 1);
                     state_n = ST_ACT;
                  end else begin
                     cmd_d   = CMD_ACT;
                     addr_d  = ADDR_W'(req_row);
                     wval    = WAIT_W'(T_RCD - 1);
                     state_n = ST_CMD;
                  end
               end
            end
         end
         ST_ACT: begin
            if (wzero) begin
               cmd_d   = CMD_ACT;
               bank_d  = lat_bank;
               addr_d  = ADDR_W'(lat_row);
               wload   = 1'b1;
               wval    = WAIT_W'(T_RCD - 1);
               state_n = ST_CMD;
            end
         end
         ST_CMD: begin
            if (wzero) begin
               cmd_d   = lat_write ? CMD_WR : CMD_RD;
               bank_d  = lat_bank;
               addr_d  = ADDR_W'(lat_col);
               ap_d    = AUTO_PRE;
               wload   = 1'b1;
               wval    = WAIT_W'(BURST_GAP - 1);
               state_n = ST_IDLE;
            end
         end
         ST_REF: begin
            if (wzero) begin
               cmd_d   = CMD_REF;
               wload   = 1'b1;
               wval    = WAIT_W'(T_RFC - 1);
               state_n = ST_IDLE;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   assign req_ready = (state == ST_IDLE) && wzero && !ref_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_INIT;
         lat_write <= 1'b0;
         lat_bank  <= '0;
         lat_row   <= '0;
         lat_col   <= '0;
         cmd_code  <= CMD_NOP;
         cmd_bank  <= '0;
         cmd_addr  <= '0;
         cmd_ap    <= 1'b0;
      end else begin
         state    <= state_n;
         cmd_code <= cmd_d;
         cmd_bank <= bank_d;
         cmd_addr <= addr_d;
         cmd_ap   <= ap_d;
         if (accept) begin
            lat_write <= req_write;
            lat_bank  <= req_bank;
            lat_row   <= req_row;
            lat_col   <= req_col;
         end
      end
   end

   // the auto-precharge variant closes the bank with the column command
   if (AUTO_PRE) begin : g_ap
      assign rw_close = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);
   end else begin : g_no_ap
      assign rw_close = 1'b0;
   end

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      assign bank_act[i] = (cmd_d == CMD_ACT) && (bank_d == BANK_W'(i));
      assign bank_pre[i] = ((cmd_d == CMD_PRE) && (ap_d || bank_d == BANK_W'(i)))
                         || (rw_close && bank_d == BANK_W'(i));
      dcs_bank_state #(.ROW_W(ROW_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .open_set (bank_act[i]),
         .close    (bank_pre[i]),
         .row_in   (addr_d[ROW_W-1:0]),
         .is_open  (open_vec[i]),
         .row_q    (row_arr[i])
      );
   end

   dcs_wait_counter #(.W(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wload),
      .load_val (wval),
      .zero     (wzero)
   );

   dcs_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_issued (cmd_d == CMD_REF),
      .pending    (ref_pending)
   );

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
   import dcs_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RP      = 3,
   parameter int T_RCD     = 3,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        cmd_code,
   input logic [BANK_W-1:0] cmd_bank,
   input logic              cmd_ap
);

   logic [NUM_BANKS-1:0] shadow;
   logic [2:0]           last_code;
   logic [7:0]           gap;
   logic                 seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow    <= '0;
         last_code <= CMD_NOP;
         gap       <= '0;
         seen      <= 1'b0;
      end else begin
         if (cmd_code != CMD_NOP) begin
            seen      <= 1'b1;
            last_code <= cmd_code;
            gap       <= 8'd1;
         end else if (gap != 8'hff) begin
            gap <= gap + 8'd1;
         end
         case (cmd_code)
            CMD_ACT: shadow[cmd_bank] <= 1'b1;
            CMD_PRE: if (cmd_ap) shadow <= '0; else shadow[cmd_bank] <= 1'b0;
            CMD_RD, CMD_WR: if (cmd_ap) shadow[cmd_bank] <= 1'b0;
            default: ;
         endcase
      end
   end

   assert_first_cmd_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen && cmd_code != CMD_NOP) |-> cmd_code == CMD_MRS);

   assert_act_to_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_code == CMD_RD || cmd_code == CMD_WR) && last_code == CMD_ACT) |-> gap >= 8'(T_RCD));

   assert_access_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> shadow[cmd_bank]);

   assert_act_needs_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_ACT) |-> !shadow[cmd_bank]);

   assert_precharge_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code != CMD_NOP && last_code == CMD_PRE) |-> gap >= 8'(T_RP));

   assert_refresh_all_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_REF) |-> shadow == '0);

   assert_accept_issues_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> cmd_code != CMD_NOP);

endmodule

bind dram_cmd_seq dcs_checker #(
   .NUM_BANKS (NUM_BANKS),
   .T_RP      (T_RP),
   .T_RCD     (T_RCD)
) u_dcs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .cmd_code  (cmd_code),
   .cmd_bank  (cmd_bank),
   .cmd_ap    (cmd_ap)
);

// File: tb/dram_cmd_seq_bench.sv
module dcs_harness
   import dcs_pkg::*;
#(
   parameter int BL      = 8,
   parameter bit AP      = 1'b0,
   parameter int REF_INT = 150
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_checks,
   output int   n_fails
);

   localparam int T_RP  = 2;
   localparam int T_RCD = 3;
   localparam int T_RFC = 4;
   localparam int BW    = BL / 2 + (AP ? T_RP : 0);

   logic       req_valid, req_ready, req_write;
   logic [1:0] req_bank;
   logic [3:0] req_row, req_col;
   logic [2:0] cmd_code;
   logic [1:0] cmd_bank;
   logic [3:0] cmd_addr;
   logic       cmd_ap;

   dram_cmd_seq #(
      .NUM_BANKS(4), .ROW_W(4), .COL_W(4), .BURST_LEN(BL), .AUTO_PRE(AP),
      .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .REF_INTERVAL(REF_INT)
   ) u_dram_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap)
   );

   int t_checks = 0, t_fails = 0, m_checks = 0, m_fails = 0;
   int ref_count = 0;
   assign n_checks = t_checks + m_checks;
   assign n_fails  = t_fails + m_fails;

   // ---------------- stream monitor (refresh rules) ----------------
   int         ncyc = 0, last_ref = 0, last_cmd_cyc = 0;
   logic [2:0] last_code = 3'd0;
   logic       last_ap = 1'b0;
   logic [3:0] shadow = 4'd0;

   always @(negedge clk) begin
      if (rst_n) begin
         ncyc = ncyc + 1;
         if (cmd_code != 3'(CMD_NOP)) begin
            if (cmd_code == 3'(CMD_REF)) begin
               m_checks = m_checks + 1;
               if (shadow != 4'd0) begin
                  m_fails = m_fails + 1;
                  $display("FAIL R7 refresh with open banks: actual %0d expected 0", shadow);
               end
               if (last_code == 3'(CMD_PRE) && last_ap) begin
                  m_checks = m_checks + 1;
                  if (ncyc - last_cmd_cyc != T_RP) begin
                     m_fails = m_fails + 1;
                     $display("FAIL R7 close-all to refresh spacing: actual %0d expected %0d",
                              ncyc - last_cmd_cyc, T_RP);
                  end
               end
               m_checks = m_checks + 1;
               if (ncyc - last_ref > REF_INT + 30) begin
                  m_fails = m_fails + 1;
                  $display("FAIL R8 refresh delayed: actual %0d expected <= %0d",
                           ncyc - last_ref, REF_INT + 30);
               end
               last_ref  = ncyc;
               ref_count = ref_count + 1;
               shadow    = 4'd0;
            end else if (cmd_code == 3'(CMD_ACT)) begin
               shadow[cmd_bank] = 1'b1;
            end else if (cmd_code == 3'(CMD_PRE)) begin
               if (cmd_ap) shadow = 4'd0;
               else shadow[cmd_bank] = 1'b0;
            end else if ((cmd_code == 3'(CMD_RD) || cmd_code == 3'(CMD_WR)) && cmd_ap) begin
               shadow[cmd_bank] = 1'b0;
            end
            last_code    = cmd_code;
            last_ap      = cmd_ap;
            last_cmd_cyc = ncyc;
         end
      end
   end

   // ---------------- request driver and expected sequences ----------------
   bit   model_open [4];
   int   model_row  [4];
   int   seen_refs = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      t_checks = t_checks + 1;
      if (!ok) begin
         t_fails = t_fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic expect_cmd(input logic [2:0] c, input int b, input int a, input bit ap,
                             input string tag);
      logic [9:0] act_v, exp_v;
      act_v = {cmd_code, cmd_bank, cmd_addr, cmd_ap};
      exp_v = {c, 2'(b), 4'(a), ap};
      chk(act_v == exp_v, tag, int'(act_v), int'(exp_v));
   endtask

   task automatic wait_gap(input int gap, input string tag);
      for (int k = 1; k < gap; k++) begin
         @(negedge clk);
         chk(cmd_code == 3'(CMD_NOP), tag, int'(cmd_code), 0);
      end
      @(negedge clk);
   endtask

   task automatic send(input bit wr, input int b, input int row, input int col);
      logic [2:0] rw;
      bit was_open, hit;
      rw        = wr ? 3'(CMD_WR) : 3'(CMD_RD);
      req_write = wr;
      req_bank  = 2'(b);
      req_row   = 4'(row);
      req_col   = 4'(col);
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      if (ref_count != seen_refs) begin
         for (int i = 0; i < 4; i++) model_open[i] = 1'b0;
         seen_refs = ref_count;
      end
      was_open = model_open[b];
      hit      = was_open && model_row[b] == row;
      @(negedge clk);
      req_valid = 1'b0;
      if (hit) begin
         expect_cmd(rw, b, col, AP, "R3 R10 open row accessed directly");
      end else begin
         if (was_open) begin
            expect_cmd(3'(CMD_PRE), b, 0, 1'b0, "R4 other row closed first");
            wait_gap(T_RP, "R4 idle during precharge wait");
            expect_cmd(3'(CMD_ACT), b, row, 1'b0, "R4 activate after precharge");
         end else begin
            expect_cmd(3'(CMD_ACT), b, row, 1'b0, "R2 activate on closed bank");
         end
         wait_gap(T_RCD, "R2 idle during activate wait");
         expect_cmd(rw, b, col, AP, AP ? "R6 access with auto-precharge" : "R2 access after activate");
      end
      chk(!req_ready, "R5 ready low at burst start", int'(req_ready), 0);
      for (int k = 1; k < BW - 1; k++) begin
         @(negedge clk);
         chk(!req_ready && cmd_code == 3'(CMD_NOP), "R5 burst spacing",
             int'({req_ready, cmd_code}), 0);
      end
      model_open[b] = !AP;
      model_row[b]  = row;
   endtask

   initial begin
      int r0;
      done      = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_bank  = '0;
      req_row   = '0;
      req_col   = '0;
      for (int i = 0; i < 4; i++) begin
         model_open[i] = 1'b0;
         model_row[i]  = 0;
      end
      @(negedge clk);
      chk(cmd_code == 3'(CMD_NOP) && !req_ready, "R9 idle and not ready in reset",
          int'({req_ready, cmd_code}), 0);
      @(posedge rst_n);
      @(negedge clk);
      expect_cmd(3'(CMD_MRS), 0, (BL == 2) ? 1 : (BL == 4) ? 2 : 3, 1'b0,
                 "R1 mode load first with burst code");
      // sweep rows across banks: mixes hits, misses and closed banks
      for (int pass = 0; pass < 6; pass++) begin
         for (int b = 0; b < 4; b++) begin
            send((pass + b) % 2 == 1, b, ((pass * (b + 1)) % 3) + 1, (b * 3 + pass) % 16);
         end
      end
      chk(ref_count >= 1, "R8 refresh served during request stream", ref_count, 1);
      r0 = ref_count;
      repeat (2 * REF_INT) @(negedge clk);
      chk(ref_count >= r0 + 1, "R7 periodic refresh while idle", ref_count, r0 + 1);
      // after a refresh every bank is closed, so this must activate
      send(1'b0, 1, 5, 9);
      // boundary row/column/bank values, issued twice
      send(1'b1, 3, 15, 15);
      send(1'b0, 3, 15, 0);
      send(1'b1, 0, 0, 15);
      done = 1'b1;
   end

endmodule

module dram_cmd_seq_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic done_a, done_b;
   int   chk_a, chk_b, fail_a, fail_b;

   always #10 clk = ~clk;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   end

   dcs_harness #(.BL(8), .AP(1'b0), .REF_INT(150)) u_ha (
      .clk(clk), .rst_n(rst_n), .done(done_a), .n_checks(chk_a), .n_fails(fail_a));

   dcs_harness #(.BL(2), .AP(1'b1), .REF_INT(130)) u_hb (
      .clk(clk), .rst_n(rst_n), .done(done_b), .n_checks(chk_b), .n_fails(fail_b));

   initial begin
      int cyc = 0;
      int wd  = 0;
      while (!(done_a === 1'b1 && done_b === 1'b1) && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!(done_a === 1'b1 && done_b === 1'b1)) begin
         wd = 1;
         $display("FAIL watchdog (R9 handshake hung): actual %0d expected < 150000", cyc);
      end
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures",
               chk_a + chk_b + wd, fail_a + fail_b + wd);
      $finish;
   end

endmodule